// File: doc/BRIEF.md
# Single-Precision Underflow Denormalizer

This block converts a double-precision operand whose magnitude lies below the single-precision normal range into its single-precision-rounded value. The result is written back in double-precision layout. The operand's sign, 11-bit exponent field and 52-bit fraction arrive on a valid/ready input. The block builds a 53-bit significand and steps it right one place per clock until the exponent reaches -126. As it shifts, bits fall into a guard bit, then a round bit, then a sticky bit.

The kept 24-bit significand is then rounded in the selected mode. The rounded value is classified. A nonzero value is shifted left one place per clock until its leading bit is set, so that a single-precision subnormal is stored as an ordinary double. The result, an underflow flag, an updated sticky inexact flag and a class code leave on a valid/ready output.

Input rules: an operand is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the block is idle. It is also high in the cycle where a finished result is being taken, so a new operand can enter in that same cycle. While the block works, `in_ready` is low and `in_valid` has no effect.

Output rules: a result is presented with `out_valid` and stays unchanged until a rising edge where `out_ready` is high. Operands are expected to have an exponent field below 897 and a nonzero value. Trap-enabled handling and other operand classes belong to other paths.

Top module: `sp_underflow_denorm`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: An exponent field of 0 starts at exponent -1022 with a leading significand bit of 0. Any other field starts at field-1023 with a leading bit of 1.
- R3: Each shift step moves the significand right by one with a 0 filled in, moves its lowest bit into guard, guard into round, and ORs round into sticky. Steps stop once the exponent is no longer below -126. At most 160 steps are taken, which leaves the outcome unchanged because every bit has reached sticky long before.
- R4: `out_underflow` is 1 exactly when, after shifting, any significand bit below the kept 24 bits, or guard, round or sticky, is nonzero. An exactly representable subnormal gives 0.
- R5: `in_rmode` selects the rounding of the kept 24 bits (significand bits 52..29, with bit 52 as the leading bit). The encodings are 00 nearest with ties to even, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R6: A round-up that carries into the leading significand position yields a normal result. For example, 1.11..1 x 2^-127 rounds to exactly 2^-126 under mode 00.
- R7: `out_inexact` = `in_inexact` OR (any discarded bit nonzero). `out_underflow` = 1 always implies `out_inexact` = 1.
- R8: A rounded significand of zero gives `out_result` = {sign, 63 zeros} and a class kind of 00.
- R9: `out_class` is {sign, kind}, where kind is 01 if the rounded leading bit is 1 and 10 if it is 0 with a nonzero value. A kind of 10 always comes with an exponent field from 874 to 896.
- R10: A nonzero result is left-normalized (exponent decremented per step) and output as {sign, exponent+1023, the 52 bits after the leading 1}.
- R11: If an operand is taken on edge A, `out_valid` rises after edge A+n+k+1. Here n is the number of shift steps and k is the number of left-normalize steps.
- R12: While busy, `in_ready` is 0, `in_valid` is ignored, and only one result is produced per accepted operand.
- R13: While `out_valid` is high and `out_ready` is low, the outputs hold steady. In the cycle a result is taken, a new operand can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be accepted |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 11 | Operand exponent field |
| in_frac | input | 52 | Operand fraction |
| in_rmode | input | 2 | Rounding mode (R5 encoding) |
| in_inexact | input | 1 | Incoming sticky inexact flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_result | output | 64 | Result in double-precision layout |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Updated sticky inexact flag |
| out_class | output | 3 | {sign, kind}: kind 00 zero, 01 normal, 10 subnormal |

## Verification
Result hand-off and operand acceptance can fall in the same cycle. This happens when `out_ready` is high while a result is shown and a new operand is waiting. The bench holds a result under back-pressure, then raises `out_ready` together with `in_valid` for a second operand. It checks that `in_ready` is high in that cycle and that `out_valid` drops after the edge. It then checks that the next result is exactly the second operand's value, with the first result seen only once.

// File: rtl/spud_pkg.sv
package spud_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    K_ZERO    = 2'b00,
    K_NORMAL  = 2'b01,
    K_SUBNORM = 2'b10
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_ROUND, S_NORM, S_DONE
  } state_e;
endpackage

// File: rtl/spud_unpack.sv
module spud_unpack #(
  parameter int EXP_W     = 11,
  parameter int FRAC_W    = 52,
  parameter int BIAS      = 1023,
  parameter int MIN_EXP   = -126,
  parameter int SHIFT_CAP = 160,
  localparam int SIG_W    = FRAC_W + 1,
  localparam int E_W      = EXP_W + 2,
  localparam int CNT_W    = $clog2(SHIFT_CAP + 1)
) (
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [FRAC_W-1:0]       frac_i,
  output logic [SIG_W-1:0]        sig_o,
  output logic signed [E_W-1:0]   exp_o,
  output logic [CNT_W-1:0]        cnt_o
);
  localparam logic signed [E_W-1:0] BIAS_S = E_W'(BIAS);
  localparam logic signed [E_W-1:0] MIN_S  = E_W'(MIN_EXP);
  localparam logic signed [E_W-1:0] CAP_S  = E_W'(SHIFT_CAP);

  logic signed [E_W-1:0] start_exp;
  logic signed [E_W-1:0] need;

  // R2: subnormal source has no hidden bit and a fixed minimum exponent
  always_comb begin
    if (exp_i == '0) start_exp = $signed(E_W'(1)) - BIAS_S;
    else             start_exp = $signed({2'b00, exp_i}) - BIAS_S;
    sig_o = {exp_i != '0, frac_i};
    need  = MIN_S - start_exp;
    // R3: steps until the exponent reaches the single-precision minimum, capped
    if (!need[E_W-1] && need != '0) begin
      cnt_o = (need > CAP_S) ? CNT_W'(SHIFT_CAP) : CNT_W'(need);
      exp_o = MIN_S;
    end else begin
      cnt_o = '0;
      exp_o = start_exp;
    end
  end
endmodule

// File: rtl/spud_round.sv
module spud_round
  import spud_pkg::*;
#(
  parameter int SIG_W  = 53,
  parameter int KEEP_W = 24,
  parameter int E_W    = 13,
  localparam int DROP_W = SIG_W - KEEP_W
) (
  input  logic                  sign_i,
  input  rmode_e                rm_i,
  input  logic [SIG_W-1:0]      sig_i,
  input  logic                  g_i,
  input  logic                  r_i,
  input  logic                  x_i,
  input  logic signed [E_W-1:0] exp_i,
  output logic [SIG_W-1:0]      sig_o,
  output logic signed [E_W-1:0] exp_o,
  output logic                  lost_o
);
  logic          lsb, gb, rb, xb, inc;
  logic [KEEP_W:0] sum;

  always_comb begin
    lsb = sig_i[DROP_W];
    gb  = sig_i[DROP_W-1];
    rb  = sig_i[DROP_W-2];
    xb  = (|sig_i[DROP_W-3:0]) | g_i | r_i | x_i;
    lost_o = gb | rb | xb;
    // R5: increment decision per mode
    unique case (rm_i)
      RM_NEAREST: inc = gb & (lsb | rb | xb);
      RM_ZERO:    inc = 1'b0;
      RM_UP:      inc = ~sign_i & lost_o;
      RM_DOWN:    inc = sign_i & lost_o;
      default:    inc = 1'b0;
    endcase
    sum   = {1'b0, sig_i[SIG_W-1:DROP_W]} + {{KEEP_W{1'b0}}, inc};
    exp_o = exp_i;
    // R6: carry out renormalizes to the next binade
    if (sum[KEEP_W]) begin
      sig_o = {1'b1, {(SIG_W-1){1'b0}}};
      exp_o = exp_i + $signed(E_W'(1));
    end else begin
      sig_o = {sum[KEEP_W-1:0], {DROP_W{1'b0}}};
    end
  end
endmodule

// File: rtl/spud_classify.sv
module spud_classify
  import spud_pkg::*;
#(
  parameter int SIG_W = 53
) (
  input  logic [SIG_W-1:0] sig_i,
  output kind_e            kind_o
);
  // R8, R9: kind taken from the rounded significand
  always_comb begin
    if (sig_i == '0)          kind_o = K_ZERO;
    else if (sig_i[SIG_W-1])  kind_o = K_NORMAL;
    else                      kind_o = K_SUBNORM;
  end
endmodule

// File: rtl/sp_underflow_denorm.sv
module sp_underflow_denorm
  import spud_pkg::*;
#(
  parameter int EXP_W        = 11,
  parameter int FRAC_W       = 52,
  parameter int NARROW_EXP_W = 8,
  parameter int KEEP_W       = 24,
  parameter int SHIFT_CAP    = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sign,
  input  logic [EXP_W-1:0]        in_exp,
  input  logic [FRAC_W-1:0]       in_frac,
  input  logic [1:0]              in_rmode,
  input  logic                    in_inexact,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [EXP_W+FRAC_W:0]   out_result,
  output logic                    out_underflow,
  output logic                    out_inexact,
  output logic [2:0]              out_class
);
  localparam int SIG_W   = FRAC_W + 1;
  localparam int E_W     = EXP_W + 2;
  localparam int CNT_W   = $clog2(SHIFT_CAP + 1);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int MIN_EXP = 2 - (1 << (NARROW_EXP_W - 1));
  localparam logic signed [E_W-1:0] BIAS_S = E_W'(BIAS);

  state_e                state_q;
  logic                  sign_q, xin_q, uf_q, xo_q;
  rmode_e                rm_q;
  logic [SIG_W-1:0]      sig_q;
  logic                  g_q, r_q, x_q;
  logic signed [E_W-1:0] exp_q;
  logic [CNT_W-1:0]      cnt_q;
  kind_e                 kind_q;

  logic [SIG_W-1:0]      up_sig, rnd_sig;
  logic signed [E_W-1:0] up_exp, rnd_exp;
  logic [CNT_W-1:0]      up_cnt;
  logic                  rnd_lost, take;
  kind_e                 rnd_kind;

  spud_unpack #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS),
    .MIN_EXP(MIN_EXP), .SHIFT_CAP(SHIFT_CAP)
  ) u_unpack (
    .exp_i(in_exp), .frac_i(in_frac),
    .sig_o(up_sig), .exp_o(up_exp), .cnt_o(up_cnt)
  );

  spud_round #(.SIG_W(SIG_W), .KEEP_W(KEEP_W), .E_W(E_W)) u_round (
    .sign_i(sign_q), .rm_i(rm_q), .sig_i(sig_q),
    .g_i(g_q), .r_i(r_q), .x_i(x_q), .exp_i(exp_q),
    .sig_o(rnd_sig), .exp_o(rnd_exp), .lost_o(rnd_lost)
  );

  spud_classify #(.SIG_W(SIG_W)) u_class (
    .sig_i(rnd_sig), .kind_o(rnd_kind)
  );

  // R12, R13: ready only when idle or when the pending result leaves now
  assign in_ready  = (state_q == S_IDLE) || (state_q == S_DONE && out_ready);
  assign take      = in_valid && in_ready;
  assign out_valid = (state_q == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sign_q  <= 1'b0;
      xin_q   <= 1'b0;
      rm_q    <= RM_NEAREST;
      sig_q   <= '0;
      g_q     <= 1'b0;
      r_q     <= 1'b0;
      x_q     <= 1'b0;
      exp_q   <= '0;
      cnt_q   <= '0;
      uf_q    <= 1'b0;
      xo_q    <= 1'b0;
      kind_q  <= K_ZERO;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE: begin
          if (take) begin
            sign_q  <= in_sign;
            rm_q    <= rmode_e'(in_rmode);
            xin_q   <= in_inexact;
            sig_q   <= up_sig;
            g_q     <= 1'b0;
            r_q     <= 1'b0;
            x_q     <= 1'b0;
            exp_q   <= up_exp;
            cnt_q   <= up_cnt;
            state_q <= (up_cnt != '0) ? S_SHIFT : S_ROUND;
          end else if (state_q == S_DONE && out_ready) begin
            state_q <= S_IDLE;
          end
        end
        S_SHIFT: begin
          // R3: guard -> round -> sticky chain, one place per clock
          x_q   <= x_q | r_q;
          r_q   <= g_q;
          g_q   <= sig_q[0];
          sig_q <= sig_q >> 1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= S_ROUND;
        end
        S_ROUND: begin
          sig_q  <= rnd_sig;
          exp_q  <= rnd_exp;
          uf_q   <= rnd_lost;          // R4: bits below single precision
          xo_q   <= xin_q | rnd_lost;  // R7
          kind_q <= rnd_kind;
          if (rnd_kind == K_SUBNORM) state_q <= S_NORM;
          else                       state_q <= S_DONE;
        end
        S_NORM: begin
          // R10: left-normalize one place per clock
          sig_q <= sig_q << 1;
          exp_q <= exp_q - $signed(E_W'(1));
          if (sig_q[SIG_W-2]) state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic [E_W-1:0] biased;
  assign biased = exp_q + BIAS_S;

  always_comb begin
    if (kind_q == K_ZERO) out_result = {sign_q, {(EXP_W+FRAC_W){1'b0}}};
    else                  out_result = {sign_q, biased[EXP_W-1:0], sig_q[FRAC_W-1:0]};
  end
  assign out_underflow = uf_q;
  assign out_inexact   = xo_q;
  assign out_class     = {sign_q, kind_q};
endmodule

// File: rtl/spud_checker.sv
module spud_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_underflow,
  input logic         out_inexact,
  input logic [2:0]   out_class
);
  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_class) && $stable(out_underflow) && $stable(out_inexact));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !out_valid);

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class[1:0] == 2'b00 |-> out_result[W-2:0] == '0);

  p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class[2] == out_result[W-1]);

  p_subnorm_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class[1:0] == 2'b10 |->
      out_result[W-2:W-12] >= 11'd874 && out_result[W-2:W-12] <= 11'd896);

  p_uf_inexact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_inexact);
endmodule

bind sp_underflow_denorm spud_checker #(.W(64)) u_spud_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_underflow(out_underflow), .out_inexact(out_inexact), .out_class(out_class)
);

// File: tb/tb_sp_underflow_denorm.sv
module tb_sp_underflow_denorm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0, in_inexact = 1'b0, out_ready = 1'b1;
  logic [10:0] in_exp = '0;
  logic [51:0] in_frac = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_ready, out_valid, out_underflow, out_inexact;
  logic [63:0] out_result;
  logic [2:0]  out_class;

  int checks = 0, errors = 0;
  logic [63:0] got_res;
  logic        got_uf, got_xo;
  logic [2:0]  got_cls;
  int          got_lat;

  always #10 clk = ~clk;

  sp_underflow_denorm dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac), .in_rmode(in_rmode),
    .in_inexact(in_inexact), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_underflow(out_underflow),
    .out_inexact(out_inexact), .out_class(out_class)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Expected behaviour computed step by step from the requirements
  function automatic void model(input logic s, input logic [10:0] ef, input logic [51:0] fr,
      input logic [1:0] rm, input logic xi, output logic [63:0] res, output logic uf,
      output logic xo, output logic [2:0] cls, output int lat);
    int e, n, k;
    logic [52:0] f;
    logic g, r, x, lsb, gb, rb, xb, inc;
    logic [24:0] top;
    if (ef == 0) begin e = -1022; f = {1'b0, fr}; end
    else begin e = int'(ef) - 1023; f = {1'b1, fr}; end
    n = (e < -126) ? ((-126 - e > 160) ? 160 : -126 - e) : 0;
    g = 0; r = 0; x = 0;
    while (e < -126) begin e++; x = x | r; r = g; g = f[0]; f = f >> 1; end
    uf = (|f[28:0]) | g | r | x;
    lsb = f[29]; gb = f[28]; rb = f[27]; xb = (|f[26:0]) | g | r | x;
    case (rm)
      2'b00: inc = gb & (lsb | rb | xb);
      2'b01: inc = 1'b0;
      2'b10: inc = !s & (gb | rb | xb);
      default: inc = s & (gb | rb | xb);
    endcase
    top = {1'b0, f[52:29]} + 25'(inc);
    if (top[24]) begin f = {1'b1, 52'b0}; e++; end
    else f = {top[23:0], 29'b0};
    xo = xi | gb | rb | xb;
    k = 0;
    if (f == 0) begin res = {s, 63'b0}; cls = {s, 2'b00}; end
    else begin
      cls = {s, f[52] ? 2'b01 : 2'b10};
      while (!f[52]) begin f = f << 1; e--; k++; end
      res = {s, 11'(e + 1023), f[51:0]};
    end
    lat = n + k + 1;
  endfunction

  // Drive one operand, wait for its result, compare all outputs to the model
  task automatic run_op(input string tag, input logic s, input logic [10:0] ef,
      input logic [51:0] fr, input logic [1:0] rm, input logic xi);
    logic [63:0] eres; logic euf, exo; logic [2:0] ecls; int elat, cyc;
    model(s, ef, fr, rm, xi, eres, euf, exo, ecls, elat);
    @(negedge clk);
    in_sign = s; in_exp = ef; in_frac = fr; in_rmode = rm; in_inexact = xi; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    while (!out_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    got_res = out_result; got_uf = out_underflow; got_xo = out_inexact;
    got_cls = out_class; got_lat = cyc;
    chk({tag, " R10 result"}, got_res, eres);
    chk({tag, " R4 underflow"}, 64'(got_uf), 64'(euf));
    chk({tag, " R7 inexact"}, 64'(got_xo), 64'(exo));
    chk({tag, " R9 class"}, 64'(got_cls), 64'(ecls));
    chk({tag, " R11 latency"}, 64'(got_lat), 64'(elat));
  endtask

  task automatic t_reset;
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_exact_subnormal;
    run_op("min-subnormal", 1'b0, 11'd874, 52'd0, 2'b00, 1'b0);
    chk("R4 exact subnormal no underflow", 64'(got_uf), 64'd0);
    chk("R10 exact subnormal value", got_res, {1'b0, 11'd874, 52'd0});
    chk("R9 exact subnormal class", 64'(got_cls), 64'(3'b010));
    chk("R11 exact subnormal latency 23+23+1", 64'(got_lat), 64'd47);
  endtask

  task automatic t_half_tie;
    run_op("half-rne", 1'b0, 11'd873, 52'd0, 2'b00, 1'b0);
    chk("R8 tie to even gives +0", got_res, 64'd0);
    chk("R8 zero class", 64'(got_cls), 64'(3'b000));
    chk("R4 tie sets underflow", 64'(got_uf), 64'd1);
    run_op("half-up", 1'b0, 11'd873, 52'd0, 2'b10, 1'b0);
    chk("R5 up mode rounds to min subnormal", got_res, {1'b0, 11'd874, 52'd0});
    run_op("half-down-neg", 1'b1, 11'd873, 52'd0, 2'b11, 1'b0);
    chk("R5 down mode negative", got_res, {1'b1, 11'd874, 52'd0});
    run_op("half-zero-neg", 1'b1, 11'd873, 52'd0, 2'b01, 1'b0);
    chk("R8 toward zero gives -0", got_res, {1'b1, 63'd0});
    chk("R9 class of -0", 64'(got_cls), 64'(3'b100));
  endtask

  task automatic t_zero_field;
    run_op("field0-rne", 1'b0, 11'd0, 52'd1, 2'b00, 1'b0);
    chk("R2 tiny source rounds to 0", got_res, 64'd0);
    chk("R3 capped shift latency", 64'(got_lat), 64'd161);
    run_op("field0-up", 1'b0, 11'd0, 52'hF_FFFF_FFFF_FFFF, 2'b10, 1'b0);
    chk("R2 field 0 sticky survives cap", got_res, {1'b0, 11'd874, 52'd0});
    chk("R7 inexact from sticky", 64'(got_xo), 64'd1);
  endtask

  task automatic t_carry;
    run_op("carry", 1'b0, 11'd896, 52'hF_FFFF_FFFF_FFFF, 2'b00, 1'b0);
    chk("R6 round-up into leading bit", got_res, {1'b0, 11'd897, 52'd0});
    chk("R6 class normal", 64'(got_cls), 64'(3'b001));
    run_op("carry-rz", 1'b0, 11'd896, 52'hF_FFFF_FFFF_FFFF, 2'b01, 1'b0);
    chk("R6 no carry toward zero", 64'(got_cls), 64'(3'b010));
  endtask

  task automatic t_patterns;
    for (int i = 0; i < 16; i++) begin
      logic [51:0] fr;
      fr = 52'h9_3C5A_71E2_D84B ^ (52'h1_0357_BEEF_0011 * 52'(i + 1));
      run_op("R5 pattern", i[0], 11'(870 + i * 2), fr, i[2:1], i[3]);
    end
    run_op("R7 inexact passthrough", 1'b0, 11'd880, 52'd0, 2'b00, 1'b1);
    chk("R7 incoming inexact kept", 64'(got_xo), 64'd1);
  endtask

  task automatic t_busy;
    logic [63:0] eres; logic euf, exo; logic [2:0] ecls; int elat, cyc, extra;
    model(1'b0, 11'd0, 52'h8_0000_0000_0000, 2'b10, 1'b0, eres, euf, exo, ecls, elat);
    @(negedge clk);
    in_sign = 0; in_exp = 0; in_frac = 52'h8_0000_0000_0000; in_rmode = 2'b10; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    repeat (5) @(negedge clk);
    in_sign = 1; in_exp = 11'd880; in_frac = 52'd5; in_valid = 1;
    chk("R12 in_ready low while busy", 64'(in_ready), 64'd0);
    @(negedge clk);
    in_valid = 0;
    cyc = 0;
    while (!out_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R12 result of first operand", out_result, eres);
    @(negedge clk);
    extra = 0;
    for (int j = 0; j < 200; j++) begin
      if (out_valid) extra++;
      @(negedge clk);
    end
    chk("R12 ignored start gives no result", 64'(extra), 64'd0);
  endtask

  task automatic t_backpressure;
    logic [63:0] e2; logic euf, exo; logic [2:0] ecls; int elat, cyc; logic [63:0] held;
    model(1'b1, 11'd885, 52'h2_468A_CE13_579B, 2'b00, 1'b0, e2, euf, exo, ecls, elat);
    @(negedge clk);
    out_ready = 0;
    in_sign = 0; in_exp = 11'd878; in_frac = 52'h7_7777_0000_1234; in_rmode = 2'b00; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    cyc = 0;
    while (!out_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    held = out_result;
    repeat (5) @(negedge clk);
    chk("R13 valid held under back-pressure", 64'(out_valid), 64'd1);
    chk("R13 result held under back-pressure", out_result, held);
    chk("R12 in_ready low while result blocked", 64'(in_ready), 64'd0);
    in_sign = 1; in_exp = 11'd885; in_frac = 52'h2_468A_CE13_579B; in_rmode = 2'b00; in_valid = 1;
    out_ready = 1;
    #1;
    chk("R13 same-cycle accept ready", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R13 first result taken once", 64'(out_valid), 64'd0);
    cyc = 0;
    while (!out_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R13 second operand result", out_result, e2);
    chk("R11 second operand latency", 64'(cyc), 64'(elat));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact_subnormal();
    t_half_tie();
    t_zero_field();
    t_carry();
    t_patterns();
    t_busy();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule